// File: doc/BRIEF.md
# Write-Masked PHY Control Register Bank

This block holds the configuration of a storage-interface PHY in a small bank of 32-bit registers reached over a simple synchronous register port. Software writes a 32-bit word whose upper half-word is a per-bit write enable for the lower half-word. A single field can therefore be changed in one write, with no read-modify-write, and with no risk of disturbing a neighbouring field that other software owns.

Seven control registers sit at word-aligned byte offsets 0x00 to 0x18. One read-only status word sits at 0x20. The control bits drive the PHY directly as output ports. Two of them are decoded into named fields: power-up, DLL enable, drive impedance, DLL frequency band and output tap delay. All seven registers also leave the block as one flat bus. The PHY's calibration-done and DLL-ready indications arrive asynchronously and are resynchronised before software can observe them.

A read is requested by holding the read strobe high for one cycle. The data appears on the read-data port after the next rising clock edge and stays there until the next read.

Top module: `phy_ctl_regbank`

## Requirements
- R1: On a write to a control register, lower bit x (0..15) takes bit x of the written word only when bit x+16 of that word is 1; every other stored bit keeps its value.
- R2: A read of a control register returns its 16 stored bits in read-data bits 15:0, and read-data bits 31:16 are always 0.
- R3: The register at offset 0x18 drives pwr_up from bit 0 (1 = powered), dll_en from bit 1, and drv_imp from bits 6:4 (0 = 50 ohm, 1 = 33 ohm, 2 = 66 ohm, 3 = 100 ohm, 4 = 40 ohm).
- R4: The register at offset 0x00 drives dll_freq from bits 13:12, otap_en from bit 11 and otap_sel from bits 10:7.
- R5: A read of offset 0x20 returns calibration done in bit 6 and DLL ready in bit 5 (1 = complete), with all other bits 0. Each input passes through two flip-flops. A read asserted in the cycle of an input change, or in the cycle after it, still returns the old value. A read asserted two cycles after the change returns the new value.
- R6: Writes to offset 0x20, to 0x1C, to offsets above 0x20 and to any offset whose two low bits are not 00 change no stored bit.
- R7: Reads from offsets other than 0x00, 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18 and 0x20 (including 0x1C and non-word-aligned offsets) return 0.
- R8: Active-low reset clears every control bit and the read data to 0, which leaves the PHY powered down with the DLL disabled.
- R9: Read data is registered. It updates only on the edge that samples the read strobe high, then holds. A read and a write to the same register in the same cycle return the value from before the write.
- R10: cfg_flat carries register k (byte offset 4k) in bits 16k+15 down to 16k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | 8 | Byte offset of the access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write word: enables in 31:16, data in 15:0 |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 32 | Registered read data |
| cal_done_in | input | 1 | Asynchronous calibration-done from the PHY |
| dll_ready_in | input | 1 | Asynchronous DLL-ready from the PHY |
| pwr_up | output | 1 | PHY power-up control |
| dll_en | output | 1 | DLL enable |
| drv_imp | output | 3 | Drive-impedance code |
| dll_freq | output | 2 | DLL frequency band select |
| otap_en | output | 1 | Output tap-delay enable |
| otap_sel | output | 4 | Output tap-delay select |
| cfg_flat | output | 112 | All seven control registers, 16 bits each |

## Verification
The hardest case to reach is the resynchroniser latency. An input change has to line up with a read strobe in the same cycle, and the next read has to follow one cycle later, so both reads see the stale value before a third read sees the new one. The bench drives the status inputs on the falling edge that opens a read and issues back-to-back reads from that point. The partial-mask cases are also deliberate. Writes with an empty enable half, with enables over only one field, and with enables spanning field edges show that the untouched bits survive.

// File: rtl/phy_ctl_pkg.sv
// Shared constants for the PHY control register bank.
// Assumes: 32-bit bus words split into an enable half and a data half.
package phy_ctl_pkg;
    localparam int HALF_W     = 16;
    localparam int WORD_W     = 2 * HALF_W;
    localparam int STATUS_OFS = 32;   // byte offset of status word

    // Register index (byte offset / 4) of the named control words
    localparam int IDX_TIMING = 0;
    localparam int IDX_POWER  = 6;

    // Field positions in the power word
    localparam int PWR_BIT    = 0;
    localparam int DLLEN_BIT  = 1;
    localparam int DRV_LSB    = 4;
    localparam int DRV_W      = 3;

    // Field positions in the timing word
    localparam int OTSEL_LSB  = 7;
    localparam int OTSEL_W    = 4;
    localparam int OTEN_BIT   = 11;
    localparam int FREQ_LSB   = 12;
    localparam int FREQ_W     = 2;

    // Status word bit positions
    localparam int ST_DLLRDY_BIT = 5;
    localparam int ST_CAL_BIT    = 6;

    // Number of asynchronous status inputs
    localparam int NUM_STAT = 2;
endpackage

// File: rtl/phy_ctl_wmreg.sv
// One control register whose bits are individually write-enabled.
// Assumes: we, din and mask are synchronous to clk; reset is synchronous.
module phy_ctl_wmreg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] din,
    input  logic [W-1:0] mask,
    output logic [W-1:0] q
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        // Update this bit only when the write hits and its enable is set
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[b] <= 1'b0;
            else if (we && mask[b])
                q[b] <= din[b];
        end
    end
endmodule

// File: rtl/phy_ctl_sync.sv
// Multi-stage flip-flop resynchroniser for a bus of independent level signals.
// Assumes: each bit is a slow level; no bus coherence between bits is needed.
module phy_ctl_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stg [STAGES];

    // First stage captures the asynchronous levels
    always_ff @(posedge clk) begin
        if (!rst_n)
            stg[0] <= '0;
        else
            stg[0] <= async_in;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each later stage shifts the previous one
        always_ff @(posedge clk) begin
            if (!rst_n)
                stg[s] <= '0;
            else
                stg[s] <= stg[s-1];
        end
    end

    assign sync_out = stg[STAGES-1];
endmodule

// File: rtl/phy_ctl_decode.sv
// Byte-offset decoder: one-hot control select plus status hit.
// Assumes: only word-aligned offsets are mapped.
module phy_ctl_decode
    import phy_ctl_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int NUM_CTRL = 7
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_CTRL-1:0] ctrl_sel,
    output logic                stat_hit
);
    for (genvar i = 0; i < NUM_CTRL; i++) begin : g_sel
        assign ctrl_sel[i] = (addr == ADDR_W'(4 * i));
    end

    assign stat_hit = (addr == ADDR_W'(STATUS_OFS));
endmodule

// File: rtl/phy_ctl_regbank.sv
// Write-masked control register bank for a storage-interface PHY.
// Upper half of each write word enables the matching lower data bits.
// Assumes: one access per cycle; status inputs are asynchronous levels.
module phy_ctl_regbank
    import phy_ctl_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int NUM_CTRL    = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic                       reg_wr,
    input  logic [31:0]                reg_wdata,
    input  logic                       reg_rd,
    output logic [31:0]                reg_rdata,
    input  logic                       cal_done_in,
    input  logic                       dll_ready_in,
    output logic                       pwr_up,
    output logic                       dll_en,
    output logic [2:0]                 drv_imp,
    output logic [1:0]                 dll_freq,
    output logic                       otap_en,
    output logic [3:0]                 otap_sel,
    output logic [NUM_CTRL*16-1:0]     cfg_flat
);
    localparam int FLAT_W = NUM_CTRL * HALF_W;

    logic [NUM_CTRL-1:0] ctrl_sel;
    logic                stat_hit;
    logic [HALF_W-1:0]   cfg_q [NUM_CTRL];
    logic [NUM_STAT-1:0] stat_sync;
    logic [HALF_W-1:0]   stat_word;
    logic [HALF_W-1:0]   rd_lower;

    phy_ctl_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_CTRL (NUM_CTRL)
    ) u_dec (
        .addr     (reg_addr),
        .ctrl_sel (ctrl_sel),
        .stat_hit (stat_hit)
    );

    for (genvar i = 0; i < NUM_CTRL; i++) begin : g_reg
        phy_ctl_wmreg #(.W(HALF_W)) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (reg_wr && ctrl_sel[i]),
            .din   (reg_wdata[HALF_W-1:0]),
            .mask  (reg_wdata[WORD_W-1:HALF_W]),
            .q     (cfg_q[i])
        );
        assign cfg_flat[i*HALF_W +: HALF_W] = cfg_q[i];
    end

    phy_ctl_sync #(
        .WIDTH  (NUM_STAT),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({dll_ready_in, cal_done_in}),
        .sync_out (stat_sync)
    );

    // Assemble the status word from the synchronised indications
    always_comb begin
        stat_word                = '0;
        stat_word[ST_CAL_BIT]    = stat_sync[0];
        stat_word[ST_DLLRDY_BIT] = stat_sync[1];
    end

    // Select the lower half-word for the addressed register
    always_comb begin
        rd_lower = '0;
        for (int i = 0; i < NUM_CTRL; i++) begin
            if (ctrl_sel[i])
                rd_lower = rd_lower | cfg_q[i];
        end
        if (stat_hit)
            rd_lower = stat_word;
    end

    // Register the read data on a read strobe, hold it otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_rdata <= '0;
        else if (reg_rd)
            reg_rdata <= {{HALF_W{1'b0}}, rd_lower};
    end

    // Named PHY control fields
    assign pwr_up   = cfg_q[IDX_POWER][PWR_BIT];
    assign dll_en   = cfg_q[IDX_POWER][DLLEN_BIT];
    assign drv_imp  = cfg_q[IDX_POWER][DRV_LSB +: DRV_W];
    assign dll_freq = cfg_q[IDX_TIMING][FREQ_LSB +: FREQ_W];
    assign otap_en  = cfg_q[IDX_TIMING][OTEN_BIT];
    assign otap_sel = cfg_q[IDX_TIMING][OTSEL_LSB +: OTSEL_W];

    if (FLAT_W != NUM_CTRL * 16) begin : g_width_guard
        initial $error("cfg_flat width mismatch");
    end
endmodule

// File: rtl/phy_ctl_regbank_checker.sv
// Property checker for the PHY control register bank, bound to its top.
// Assumes: the default register map (power word at 0x18, timing word at 0x00).
module phy_ctl_regbank_checker #(
    parameter int ADDR_W   = 8,
    parameter int NUM_CTRL = 7
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [ADDR_W-1:0]      reg_addr,
    input logic                   reg_wr,
    input logic [31:0]            reg_wdata,
    input logic                   reg_rd,
    input logic [31:0]            reg_rdata,
    input logic                   pwr_up,
    input logic                   dll_en,
    input logic [2:0]             drv_imp,
    input logic [1:0]             dll_freq,
    input logic                   otap_en,
    input logic [3:0]             otap_sel,
    input logic [NUM_CTRL*16-1:0] cfg_flat
);
    localparam logic [ADDR_W-1:0] A_POWER  = ADDR_W'(24);
    localparam logic [ADDR_W-1:0] A_TIMING = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(32);
    localparam logic [ADDR_W-1:0] A_HOLE   = ADDR_W'(28);

    assert_reset_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cfg_flat == '0 && !pwr_up && !dll_en && reg_rdata == '0));

    assert_masked_keep_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_POWER && reg_wdata[22:20] == 3'b000) |=> $stable(drv_imp));

    assert_power_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_POWER && reg_wdata[16]) |=> (pwr_up == $past(reg_wdata[0])));

    assert_freq_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_TIMING && reg_wdata[29:28] == 2'b11) |=>
        (dll_freq == $past(reg_wdata[13:12])));

    assert_tap_update_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_TIMING && reg_wdata[27]) |=>
        (otap_en == $past(reg_wdata[11])));

    assert_tap_keep_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_TIMING && reg_wdata[26:23] == 4'b0000) |=> $stable(otap_sel));

    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> (reg_rdata[31:16] == 16'h0000));

    assert_status_layout_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == A_STATUS) |=> (reg_rdata[4:0] == 5'b0 && reg_rdata[31:7] == '0));

    assert_status_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == A_STATUS || reg_addr == A_HOLE || reg_addr[1:0] != 2'b00))
        |=> $stable(cfg_flat));

    assert_hole_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && (reg_addr == A_HOLE || reg_addr[1:0] != 2'b00)) |=> (reg_rdata == '0));

    assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> $stable(reg_rdata));
endmodule

bind phy_ctl_regbank phy_ctl_regbank_checker #(
    .ADDR_W   (ADDR_W),
    .NUM_CTRL (NUM_CTRL)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata),
    .pwr_up    (pwr_up),
    .dll_en    (dll_en),
    .drv_imp   (drv_imp),
    .dll_freq  (dll_freq),
    .otap_en   (otap_en),
    .otap_sel  (otap_sel),
    .cfg_flat  (cfg_flat)
);

// File: tb/phy_ctl_regbank_test.sv
// Self-checking bench: table-driven masked writes, then directed corner cases.
module phy_ctl_regbank_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCTRL      = 7;
    localparam int NVEC       = 12;

    // Row: {byte offset, write word, expected readback}
    localparam logic [71:0] VEC [NVEC] = '{
        {8'h18, 32'h0001_FFFF, 32'h0000_0001},
        {8'h18, 32'h0072_0030, 32'h0000_0031},
        {8'h18, 32'h0003_0002, 32'h0000_0032},
        {8'h00, 32'h3FFF_2A80, 32'h0000_2A80},
        {8'h00, 32'h0000_FFFF, 32'h0000_2A80},
        {8'h04, 32'hFFFF_A5A5, 32'h0000_A5A5},
        {8'h04, 32'h00F0_0000, 32'h0000_A505},
        {8'h08, 32'hFFFF_1234, 32'h0000_1234},
        {8'h0C, 32'hFFFF_5678, 32'h0000_5678},
        {8'h10, 32'hFFFF_9ABC, 32'h0000_9ABC},
        {8'h14, 32'hFFFF_DEF0, 32'h0000_DEF0},
        {8'h00, 32'h8000_FFFF, 32'h0000_AA80}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   reg_addr = '0;
    logic         reg_wr = 1'b0;
    logic [31:0]  reg_wdata = '0;
    logic         reg_rd = 1'b0;
    logic [31:0]  reg_rdata;
    logic         cal_done_in = 1'b0;
    logic         dll_ready_in = 1'b0;
    logic         pwr_up, dll_en, otap_en;
    logic [2:0]   drv_imp;
    logic [1:0]   dll_freq;
    logic [3:0]   otap_sel;
    logic [NCTRL*16-1:0] cfg_flat;

    int checks = 0;
    int errors = 0;
    logic [15:0] shadow [NCTRL];
    logic [31:0] rd;
    bit done = 1'b0;

    phy_ctl_regbank uut (
        .clk (clk), .rst_n (rst_n), .reg_addr (reg_addr), .reg_wr (reg_wr),
        .reg_wdata (reg_wdata), .reg_rd (reg_rd), .reg_rdata (reg_rdata),
        .cal_done_in (cal_done_in), .dll_ready_in (dll_ready_in),
        .pwr_up (pwr_up), .dll_en (dll_en), .drv_imp (drv_imp),
        .dll_freq (dll_freq), .otap_en (otap_en), .otap_sel (otap_sel),
        .cfg_flat (cfg_flat)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge
    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    function automatic logic [NCTRL*16-1:0] pack_shadow();
        logic [NCTRL*16-1:0] p;
        for (int k = 0; k < NCTRL; k++) p[k*16 +: 16] = shadow[k];
        return p;
    endfunction

    initial begin
        for (int k = 0; k < NCTRL; k++) shadow[k] = '0;
        repeat (3) @(negedge clk);

        // R8: outputs cleared while reset is held
        check("R8 reset cfg_flat", cfg_flat, '0);
        check("R8 reset pwr/dll", {pwr_up, dll_en}, 2'b00);
        check("R8 reset rdata", reg_rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int k = 0; k < NCTRL; k++) begin
            do_read(8'(4*k), rd);
            check("R8 reset readback", rd, 32'h0);
        end

        // R1 R2: table of masked writes with readback
        for (int v = 0; v < NVEC; v++) begin
            logic [7:0]  a;
            logic [31:0] w, e;
            {a, w, e} = VEC[v];
            do_write(a, w);
            do_read(a, rd);
            check("R1 masked write readback", rd, e);
            shadow[a[4:2]] = e[15:0];
        end

        // R3 R4: decoded fields after the table
        check("R3 pwr_up", pwr_up, 1'b0);
        check("R3 dll_en", dll_en, 1'b1);
        check("R3 drv_imp 100 ohm", drv_imp, 3'd3);
        check("R4 dll_freq", dll_freq, 2'd2);
        check("R4 otap_en", otap_en, 1'b1);
        check("R4 otap_sel", otap_sel, 4'd5);
        do_write(8'h18, 32'h0070_0040);
        shadow[6] = 16'h0042;
        check("R3 drv_imp 40 ohm", drv_imp, 3'd4);
        check("R3 dll_en kept", dll_en, 1'b1);
        check("R10 cfg_flat layout", cfg_flat, pack_shadow());
        check("R10 slot 5", cfg_flat[5*16 +: 16], 16'hDEF0);

        // R6: writes to status, hole and unaligned offsets change nothing
        do_write(8'h20, 32'hFFFF_FFFF);
        do_write(8'h1C, 32'hFFFF_FFFF);
        do_write(8'h19, 32'hFFFF_FFFF);
        do_write(8'h02, 32'hFFFF_FFFF);
        do_write(8'h40, 32'hFFFF_FFFF);
        check("R6 ignored writes cfg_flat", cfg_flat, pack_shadow());
        for (int k = 0; k < NCTRL; k++) begin
            do_read(8'(4*k), rd);
            check("R6 readback after ignored writes", rd, {16'h0, shadow[k]});
        end

        // R7: unmapped reads return zero
        do_read(8'h1C, rd); check("R7 read 0x1C", rd, 32'h0);
        do_read(8'h24, rd); check("R7 read 0x24", rd, 32'h0);
        do_read(8'h01, rd); check("R7 read 0x01", rd, 32'h0);
        do_read(8'h1A, rd); check("R7 read 0x1A", rd, 32'h0);
        do_read(8'hFC, rd); check("R7 read 0xFC", rd, 32'h0);

        // R5: two-flop latency then status layout
        cal_done_in = 1'b1;
        do_read(8'h20, rd); check("R5 status stale cycle 0", rd, 32'h0);
        do_read(8'h20, rd); check("R5 status stale cycle 1", rd, 32'h0);
        do_read(8'h20, rd); check("R5 cal done bit 6", rd, 32'h0000_0040);
        dll_ready_in = 1'b1;
        repeat (2) @(negedge clk);
        do_read(8'h20, rd); check("R5 both done", rd, 32'h0000_0060);
        cal_done_in = 1'b0;
        repeat (2) @(negedge clk);
        do_read(8'h20, rd); check("R5 dll ready bit 5", rd, 32'h0000_0020);

        // R9: read data holds without a read strobe
        dll_ready_in = 1'b0;
        do_write(8'h08, 32'hFFFF_0F0F);
        shadow[2] = 16'h0F0F;
        repeat (3) @(negedge clk);
        check("R9 rdata holds", reg_rdata, 32'h0000_0020);

        // R9: simultaneous read and write returns the old value
        reg_addr = 8'h04; reg_wdata = 32'hFFFF_0001; reg_wr = 1'b1; reg_rd = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0;
        check("R9 read during write old value", reg_rdata, 32'h0000_A505);
        shadow[1] = 16'h0001;
        do_read(8'h04, rd);
        check("R9 read after write new value", rd, 32'h0000_0001);

        // R2: upper half of a fully written register reads zero
        do_write(8'h10, 32'hFFFF_FFFF);
        do_read(8'h10, rd);
        check("R2 upper half zero", rd, 32'h0000_FFFF);

        // R8: reset in mid-run clears everything
        rst_n = 1'b0;
        @(negedge clk);
        check("R8 mid-run cfg_flat", cfg_flat, '0);
        check("R8 mid-run fields", {pwr_up, dll_en, drv_imp, dll_freq, otap_en, otap_sel}, '0);
        check("R8 mid-run rdata", reg_rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        do_read(8'h00, rd);
        check("R8 readback after reset", rd, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule